// File: doc/BRIEF.md
# Frame Lock Detector with Error Concealment

This block sits behind a digital audio receiver's frame demodulator. For every received frame it gets a strobe, a flag saying whether the frame's sync preamble was recognised, a flag saying whether the sample failed its parity check, the clock-recovery lock status and the sample itself. From these it produces a lock flag, an error flag, a concealed audio sample, and two one-cycle pulses. The pulses tell the channel-status capture registers to hold their contents or to clear them.

Three small state machines do the work. The lock machine (`LK_SEEK`, `LK_ONE`, `LK_HELD`) needs two consecutive well-formed frames before it reports lock. It goes back to `LK_SEEK` when a preamble is missing, when the recovered clock unlocks, or when the block is forced off. The concealment machine records how the last frame was treated: `CN_PASS` for a good sample, `CN_REPEAT` while a parity burst is short, `CN_MUTE` once the burst is long, and `CN_CLEAR` for a frame arriving without lock. The error machine (`ER_FAULT`, `ER_HOLD`, `ER_QUIET`) raises the error flag on any bad frame. It lowers the flag only after a run of clean frames. Counting the run in frames makes the hold time scale inversely with the sample rate.

The block is forced off when `run_en` is low (system start not yet given), when `halt` is high, or when `fallback_mode` reports that no input is present. While forced off, lock is low and error is high.

Top module: `frame_guard`

## Requirements
- R1: `lock_o` rises in the clock cycle after the frame strobe of the second consecutive frame that has `preamble_ok` high while `pll_locked` is high.
- R2: A frame strobe with `preamble_ok` low, or `pll_locked` low in any cycle, makes `lock_o` low in the next cycle. The two-frame count of R1 then restarts from zero.
- R3: A frame that is not a lock error and has `parity_err` low puts its sample on `sample_o` one cycle after the strobe. The sample is stored as the last good sample and the consecutive parity-error count returns to zero.
- R4: The 1st to the 8th (`BURST_MAX`) consecutive parity-error frames without a lock error output the stored last good sample. Each one pulses `cs_hold` for one cycle.
- R5: From the 9th consecutive parity-error frame onward, `sample_o` is zero and `cs_hold` still pulses on each such frame.
- R6: A lock error frame gives `sample_o` zero and a one-cycle `cs_clear` pulse, and clears the stored last good sample to zero. A lock error frame is one where `lock_o` was low before the strobe, or `preamble_ok` or `pll_locked` is low at the strobe, or the block is forced off.
- R7: A lock error frame or a parity-error frame sets `error_o` high in the next cycle. `error_o` falls one cycle after the strobe of the `HOLD_FRAMES`-th consecutive clean frame (default 12288). Any bad frame restarts the count.
- R8: When `run_en` is low, `halt` is high or `fallback_mode` is high, `lock_o` is low and `error_o` is high from the next cycle onward.
- R9: After reset, `lock_o`, `sample_o`, `cs_hold` and `cs_clear` are zero and `error_o` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | System start; low forces the block off |
| halt | input | 1 | Clock recovery stopped; high forces the block off |
| fallback_mode | input | 1 | No-input fallback active; high forces the block off |
| pll_locked | input | 1 | Clock-recovery lock status |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| preamble_ok | input | 1 | Preamble of this frame recognised |
| parity_err | input | 1 | Sample of this frame failed parity |
| sample_in | input | SAMPLE_W | Sample carried by this frame |
| lock_o | output | 1 | Lock flag |
| error_o | output | 1 | Error flag with release hold |
| sample_o | output | SAMPLE_W | Concealed sample |
| cs_hold | output | 1 | Pulse: channel-status registers keep their value |
| cs_clear | output | 1 | Pulse: channel-status registers clear |

## Verification
The concealment function is driven with parity-error bursts of every length from zero to twelve, each followed by a good frame. This separates the repeat tier from the mute tier at exactly the eighth/ninth boundary. It also shows that a good sample resets the burst count. Bursts are also sent straight after lock is regained, before any good sample, so a stale stored sample would show up instead of zero. Lock is broken three ways: a missing preamble at a strobe, a clock unlock between frames, and each forcing input. This tells apart the per-frame and the per-cycle drop paths. The release of the error flag is checked frame by frame against an arithmetic count of clean frames, which catches an off-by-one in the hold length.

// File: rtl/frame_guard_pkg.sv
package frame_guard_pkg;

    typedef enum logic [1:0] {
        LK_SEEK = 2'd0,
        LK_ONE  = 2'd1,
        LK_HELD = 2'd2
    } lock_st_t;

    typedef enum logic [1:0] {
        CN_PASS   = 2'd0,
        CN_REPEAT = 2'd1,
        CN_MUTE   = 2'd2,
        CN_CLEAR  = 2'd3
    } conceal_st_t;

    typedef enum logic [1:0] {
        ER_FAULT = 2'd0,
        ER_HOLD  = 2'd1,
        ER_QUIET = 2'd2
    } err_st_t;

endpackage

// File: rtl/fg_lock_fsm.sv
module fg_lock_fsm
    import frame_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic pll_locked,
    input  logic frame_stb,
    input  logic preamble_ok,
    output logic lock_o
);

    lock_st_t st, st_nxt;
    logic     frame_ok;
    logic     drop;

    assign frame_ok = frame_stb && preamble_ok && pll_locked;
    assign drop     = force_off || !pll_locked || (frame_stb && !preamble_ok);

    always_comb begin
        st_nxt = st;
        unique case (st)
            LK_SEEK: if (frame_ok) st_nxt = LK_ONE;
            LK_ONE:  if (frame_ok) st_nxt = LK_HELD;
            LK_HELD: st_nxt = LK_HELD;
            default: st_nxt = LK_SEEK;
        endcase
        if (drop) st_nxt = LK_SEEK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LK_SEEK;
        else        st <= st_nxt;
    end

    always_comb begin
        lock_o = (st == LK_HELD);
    end

    // R1: lock appears only right after a well-formed frame
    p_rise_after_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(frame_stb && preamble_ok && pll_locked));

    // R2: a missing preamble drops lock
    p_preamble_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !preamble_ok) |=> !lock_o);

    // R2: clock unlock drops lock
    p_pll_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> !lock_o);

    // R8: forced off means no lock
    p_forced_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !lock_o);

endmodule

// File: rtl/fg_conceal.sv
module fg_conceal
    import frame_guard_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int BURST_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic                lock_err,
    input  logic                parity_err,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                cs_hold,
    output logic                cs_clear
);

    localparam int CNT_W = $clog2(BURST_MAX + 2);
    localparam logic [CNT_W-1:0] BURST_TOP  = CNT_W'(BURST_MAX + 1);
    localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_MAX);

    conceal_st_t         st, st_nxt;
    logic [CNT_W-1:0]    burst, burst_nxt, burst_inc;
    logic [SAMPLE_W-1:0] last_good, last_nxt;
    logic                fresh;

    assign burst_inc = (burst == BURST_TOP) ? burst : burst + 1'b1;

    always_comb begin
        st_nxt    = st;
        burst_nxt = burst;
        last_nxt  = last_good;
        if (frame_stb) begin
            if (lock_err) begin
                st_nxt    = CN_CLEAR;
                burst_nxt = '0;
                last_nxt  = '0;
            end else if (parity_err) begin
                burst_nxt = burst_inc;
                st_nxt    = (burst_inc <= BURST_LAST) ? CN_REPEAT : CN_MUTE;
            end else begin
                st_nxt    = CN_PASS;
                burst_nxt = '0;
                last_nxt  = sample_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= CN_CLEAR;
            burst     <= '0;
            last_good <= '0;
            fresh     <= 1'b0;
        end else begin
            st        <= st_nxt;
            burst     <= burst_nxt;
            last_good <= last_nxt;
            fresh     <= frame_stb;
        end
    end

    always_comb begin
        sample_o = '0;
        cs_hold  = 1'b0;
        cs_clear = 1'b0;
        unique case (st)
            CN_PASS:   sample_o = last_good;
            CN_REPEAT: begin
                sample_o = last_good;
                cs_hold  = fresh;
            end
            CN_MUTE:   cs_hold  = fresh;
            CN_CLEAR:  cs_clear = fresh;
            default:   sample_o = '0;
        endcase
    end

    // R5: burst counter saturates
    p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst <= BURST_TOP);

    // R6: lock error frame mutes and clears
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && lock_err) |=> (sample_o == '0 && cs_clear));

    // R4: short burst keeps the output unchanged and holds status
    p_repeat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !lock_err && parity_err && burst < BURST_LAST)
        |=> ($stable(sample_o) && cs_hold));

    // R4: hold and clear never pulse together
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_hold, cs_clear}));

endmodule

// File: rtl/fg_err_hold.sv
module fg_err_hold
    import frame_guard_pkg::*;
#(
    parameter int HOLD_FRAMES = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic pll_locked,
    input  logic frame_stb,
    input  logic frame_bad,
    output logic error_o
);

    localparam int HCW = $clog2(HOLD_FRAMES + 1);
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_FRAMES - 1);

    err_st_t        st, st_nxt;
    logic [HCW-1:0] cnt, cnt_nxt;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        if (frame_stb) begin
            unique case (st)
                ER_FAULT: begin
                    st_nxt  = ER_HOLD;
                    cnt_nxt = HCW'(1);
                end
                ER_HOLD: begin
                    if (cnt == HOLD_LAST) st_nxt = ER_QUIET;
                    else                  cnt_nxt = cnt + 1'b1;
                end
                ER_QUIET: st_nxt = ER_QUIET;
                default:  st_nxt = ER_FAULT;
            endcase
            if (frame_bad) begin
                st_nxt  = ER_FAULT;
                cnt_nxt = '0;
            end
        end
        if (force_off || !pll_locked) begin
            st_nxt  = ER_FAULT;
            cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ER_FAULT;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        error_o = (st != ER_QUIET);
    end

    // R7: a bad frame raises the error flag
    p_bad_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_bad) |=> error_o);

    // R7: release only at a clean frame strobe
    p_release_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error_o) |-> $past(frame_stb && !frame_bad));

    // R8: forced off keeps the error flag high
    p_forced_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> error_o);

endmodule

// File: rtl/frame_guard.sv
module frame_guard
    import frame_guard_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int BURST_MAX   = 8,
    parameter int HOLD_FRAMES = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                halt,
    input  logic                fallback_mode,
    input  logic                pll_locked,
    input  logic                frame_stb,
    input  logic                preamble_ok,
    input  logic                parity_err,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                lock_o,
    output logic                error_o,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                cs_hold,
    output logic                cs_clear
);

    logic force_off;
    logic lock_err;
    logic frame_bad;

    assign force_off = !run_en || halt || fallback_mode;
    assign lock_err  = !lock_o || !preamble_ok || !pll_locked || force_off;
    assign frame_bad = lock_err || parity_err;

    fg_lock_fsm u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_off   (force_off),
        .pll_locked  (pll_locked),
        .frame_stb   (frame_stb),
        .preamble_ok (preamble_ok),
        .lock_o      (lock_o)
    );

    fg_conceal #(
        .SAMPLE_W  (SAMPLE_W),
        .BURST_MAX (BURST_MAX)
    ) u_conceal (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .lock_err   (lock_err),
        .parity_err (parity_err),
        .sample_in  (sample_in),
        .sample_o   (sample_o),
        .cs_hold    (cs_hold),
        .cs_clear   (cs_clear)
    );

    fg_err_hold #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_off  (force_off),
        .pll_locked (pll_locked),
        .frame_stb  (frame_stb),
        .frame_bad  (frame_bad),
        .error_o    (error_o)
    );

    // R7: without lock the error flag is always raised
    p_unlocked_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> error_o);

endmodule

// File: tb/tb_frame_guard.sv
module tb_frame_guard;

    localparam int SW   = 8;
    localparam int BMAX = 8;
    localparam int HOLD = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          halt = 1'b0;
    logic          fallback_mode = 1'b0;
    logic          pll_locked = 1'b1;
    logic          frame_stb = 1'b0;
    logic          preamble_ok = 1'b1;
    logic          parity_err = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic          lock_o, error_o, cs_hold, cs_clear;
    logic [SW-1:0] sample_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    int            m_good = 0;
    bit            m_lock = 0;
    int            m_burst = 0;
    int            m_clean = 0;
    logic [SW-1:0] m_last = '0;
    logic [SW-1:0] lfsr = 8'h5a;

    always #10 clk = ~clk;

    frame_guard #(.SAMPLE_W(SW), .BURST_MAX(BMAX), .HOLD_FRAMES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .halt(halt),
        .fallback_mode(fallback_mode), .pll_locked(pll_locked),
        .frame_stb(frame_stb), .preamble_ok(preamble_ok),
        .parity_err(parity_err), .sample_in(sample_in),
        .lock_o(lock_o), .error_o(error_o), .sample_o(sample_o),
        .cs_hold(cs_hold), .cs_clear(cs_clear)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] next_val();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr;
    endfunction

    task automatic model_drop();
        m_good  = 0;
        m_lock  = 0;
        m_clean = 0;
    endtask

    task automatic send(bit pre, bit perr, logic [SW-1:0] val);
        bit            forced;
        bit            lerr;
        logic [SW-1:0] exp_s;
        bit            exp_h;
        string         stag;
        @(negedge clk);
        frame_stb   = 1'b1;
        preamble_ok = pre;
        parity_err  = perr;
        sample_in   = val;
        forced = !run_en || halt || fallback_mode;
        lerr   = !m_lock || !pre || !pll_locked || forced;
        exp_h  = 0;
        if (lerr) begin
            exp_s = '0; m_last = '0; m_burst = 0; stag = "R6 sample";
        end else if (perr) begin
            m_burst++;
            exp_h = 1;
            if (m_burst <= BMAX) begin exp_s = m_last; stag = "R4 sample"; end
            else                 begin exp_s = '0;     stag = "R5 sample"; end
        end else begin
            exp_s = val; m_last = val; m_burst = 0; stag = "R3 sample";
        end
        if (!pre || !pll_locked || forced) model_drop();
        else begin
            m_good++;
            m_lock = (m_good >= 2);
        end
        if (lerr || perr) m_clean = 0;
        else              m_clean++;
        @(negedge clk);
        frame_stb = 1'b0;
        check(stag, int'(sample_o), int'(exp_s));
        check("R1/R2 lock", int'(lock_o), int'(m_lock));
        check("R7 error", int'(error_o), int'(m_clean < HOLD));
        check("R4/R5 cs_hold", int'(cs_hold), int'(exp_h));
        check("R6 cs_clear", int'(cs_clear), int'(lerr));
        @(negedge clk);
        check("R4 hold pulse width", int'(cs_hold), 0);
        check("R6 clear pulse width", int'(cs_clear), 0);
        @(negedge clk);
    endtask

    task automatic good_run(int n);
        for (int i = 0; i < n; i++) send(1, 0, next_val());
    endtask

    task automatic force_test(int which);
        @(negedge clk);
        if (which == 0) run_en = 1'b0;
        if (which == 1) halt = 1'b1;
        if (which == 2) fallback_mode = 1'b1;
        model_drop();
        @(negedge clk);
        check("R8 forced lock", int'(lock_o), 0);
        check("R8 forced error", int'(error_o), 1);
        send(1, 0, next_val());
        check("R8 forced lock after frame", int'(lock_o), 0);
        run_en = 1'b1;
        halt = 1'b0;
        fallback_mode = 1'b0;
        good_run(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 lock", int'(lock_o), 0);
        check("R9 error", int'(error_o), 1);
        check("R9 sample", int'(sample_o), 0);
        check("R9 cs_hold", int'(cs_hold), 0);
        check("R9 cs_clear", int'(cs_clear), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 not started", int'(error_o), 1);
        run_en = 1'b1;

        // R1: lock after two good frames, then error release
        send(1, 0, next_val());
        check("R1 one frame no lock", int'(lock_o), 0);
        send(1, 0, next_val());
        check("R1 lock at second frame", int'(lock_o), 1);
        good_run(HOLD + 2);
        check("R7 error released", int'(error_o), 0);

        // R4 R5: burst length sweep, each closed by a good frame
        for (int len = 0; len <= 12; len++) begin
            send(1, 0, next_val());
            for (int k = 0; k < len; k++) send(1, 1, next_val());
            send(1, 0, next_val());
        end
        good_run(HOLD + 1);
        check("R7 released after bursts", int'(error_o), 0);

        // R2: missing preamble, relock, burst before any good sample
        send(0, 0, next_val());
        check("R2 preamble drop", int'(lock_o), 0);
        send(1, 0, next_val());
        send(1, 0, next_val());
        send(1, 1, next_val());
        send(1, 1, next_val());
        check("R6 last good cleared", int'(sample_o), 0);
        good_run(4);

        // R2: clock unlock between frames
        @(negedge clk);
        pll_locked = 1'b0;
        model_drop();
        @(negedge clk);
        check("R2 pll drop lock", int'(lock_o), 0);
        check("R2 pll drop error", int'(error_o), 1);
        send(1, 0, next_val());
        pll_locked = 1'b1;
        good_run(3);

        // R8: each forcing input
        for (int w = 0; w < 3; w++) force_test(w);

        // R7: exact hold, interrupted once
        good_run(HOLD - 3);
        send(1, 1, next_val());
        good_run(HOLD + 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule